// File: doc/BRIEF.md
# SPI Flash Command Opcode Dispatcher

This block looks at the first byte of every SPI transaction, after chip select goes active and the byte has been assembled, and decides which downstream engine owns the rest of that transaction. The byte is compared against a table of command entries loaded by configuration logic. Each entry carries an enable bit, an 8-bit opcode, an upload attribute and a 2-bit read-pipeline mode. The outcome is a single routing decision: a status read, an ID read, a discovery-table read, a generic read, an upload, an address-width change, a write-latch change, or a wait path that absorbs the transaction.

The decision is made once, registered, and held until the transaction reset. That reset is the asynchronous active-low `rst_n`, which is driven from chip-select release. State-changing commands are honoured only while the device is not busy. When the bridge forwards traffic to a downstream flash, the three local read commands can be kept local or forwarded. A per-command flag reports each one that is forwarded.

Fixed slot layout: slots 0-2 status read, slot 3 ID read, slot 4 discovery read, slot 5 enter 4-byte, slot 6 exit 4-byte, slot 7 write enable, slot 8 write disable, slots 9 to 9+READ_CNT-1 generic reads. Higher slots are general (for example, upload commands).

Top module: `spi_opdisp`

## Requirements
- R1: A table slot matches only if its enable bit is set and its opcode equals the received byte. A byte that matches no slot moves the block into the wait path: `cmd_taken_o`=1 and `dp_sel_o`=0.
- R2: A match on any of the slots 0, 1 or 2 selects the status datapath (`dp_sel_o` bit 0).
- R3: In flash mode, slot 3 selects the ID datapath (bit 1), slot 4 selects the discovery datapath (bit 2), and a generic read slot selects the read datapath (bit 3).
- R4: Slots 5 and 6 select the address-width datapath (bit 5), with `addr4b_enter_o` set to 1 for slot 5 and 0 for slot 6. Slots 7 and 8 select the write-latch datapath (bit 6), with `wr_enable_o` set to 1 for slot 7 and 0 for slot 8. All four are recognised only while `busy_i`=0; when busy, the command goes to the wait path.
- R5: If the first matching slot has its upload attribute set and no earlier class applies, the upload datapath (bit 4) is selected when `busy_i`=0. When `busy_i`=1, the wait path is taken instead.
- R6: Bytes are acted on only in flash mode (`mode_i`=2'b01) or passthrough mode (`mode_i`=2'b10). In the other two modes the block stays idle, with `cmd_taken_o`=0 and `dp_sel_o`=0.
- R7: Only the first valid byte after reset is decoded. Later bytes change no output until the next reset.
- R8: In passthrough mode, each status, ID or discovery command is kept local only if its bit in `icpt_en_i` is set (bit 0 status, bit 1 ID, bit 2 discovery). Otherwise the wait path is taken and the matching bit of `fwd_o` is raised. In flash mode these commands are always local and `fwd_o` stays 0.
- R9: `pipe2_o` is 1 when the first matching slot's pipeline mode is 2'b01 or 2'b10. It is 0 for 2'b00, for 2'b11 and when nothing matches.
- R10: After reset all outputs are 0. `dp_sel_o` is always one-hot or zero, and it is zero in the idle and wait states.
- R11: When several classes match, priority is status, ID, discovery, generic read, upload, address-width, write-latch. For example, a generic read slot that also has the upload attribute is routed to the read datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low transaction reset |
| mode_i | input | 2 | 01 flash, 10 passthrough, others inactive |
| busy_i | input | 1 | Device busy status bit |
| byte_valid_i | input | 1 | Qualifies byte_i |
| byte_i | input | 8 | Received byte |
| tbl_valid_i | input | N_SLOTS | Per-slot enable |
| tbl_opcode_i | input | 8*N_SLOTS | Per-slot opcode, slot i at bits [8i+7:8i] |
| tbl_upload_i | input | N_SLOTS | Per-slot upload attribute |
| tbl_pipe_i | input | 2*N_SLOTS | Per-slot read pipeline mode |
| icpt_en_i | input | 3 | Keep-local enables in passthrough |
| dp_sel_o | output | 7 | One-hot datapath select |
| cmd_taken_o | output | 1 | The first byte has been decoded |
| addr4b_enter_o | output | 1 | 1 enter, 0 exit 4-byte |
| wr_enable_o | output | 1 | 1 enable, 0 disable write latch |
| fwd_o | output | 3 | Forwarded-command flags |
| pipe2_o | output | 1 | Two-stage pipeline requested |

## Verification
The embedded assertions check on every cycle that `dp_sel_o` is one-hot or zero, that a state once left idle is held, that an inactive mode keeps the block idle, that busy blocks the address, write-latch and upload paths, and that an unmatched byte lands in the wait path. Only the bench scenarios can show that each slot routes to the right datapath, that the enter/exit and enable/disable selects have the right polarity, that forwarding flags and pipeline flags carry the right values, and that class priority resolves as specified.

// File: rtl/spi_opdisp_pkg.sv
package spi_opdisp_pkg;
   localparam int SLOT_STAT0   = 0;
   localparam int STAT_CNT     = 3;
   localparam int SLOT_ID      = 3;
   localparam int SLOT_DISC    = 4;
   localparam int SLOT_EN4B    = 5;
   localparam int SLOT_EX4B    = 6;
   localparam int SLOT_WREN    = 7;
   localparam int SLOT_WRDI    = 8;
   localparam int SLOT_READ0   = 9;
   localparam int DP_W         = 7;

   localparam int DP_STAT   = 0;
   localparam int DP_ID     = 1;
   localparam int DP_DISC   = 2;
   localparam int DP_READ   = 3;
   localparam int DP_UPLD   = 4;
   localparam int DP_ADDR   = 5;
   localparam int DP_WRL    = 6;

   localparam logic [1:0] MODE_FLASH = 2'b01;
   localparam logic [1:0] MODE_PASS  = 2'b10;
   localparam logic [1:0] PIPE_HALF  = 2'b01;
   localparam logic [1:0] PIPE_FULL  = 2'b10;

   typedef struct packed {
      logic stat;
      logic id;
      logic disc;
      logic rd;
      logic en4b;
      logic ex4b;
      logic wren;
      logic wrdi;
   } hit_t;

   typedef enum logic [3:0] {
      ST_IDLE, ST_STAT, ST_ID, ST_DISC, ST_READ,
      ST_UPLD, ST_ADDR, ST_WRL, ST_WAIT
   } state_e;
endpackage

// File: rtl/spi_opdisp_match.sv
module spi_opdisp_match
   import spi_opdisp_pkg::*;
#(
   parameter int N_SLOTS  = 20,
   parameter int READ_CNT = 6
) (
   input  logic [7:0]           byte_i,
   input  logic [N_SLOTS-1:0]   tbl_valid_i,
   input  logic [8*N_SLOTS-1:0] tbl_opcode_i,
   input  logic [N_SLOTS-1:0]   tbl_upload_i,
   input  logic [2*N_SLOTS-1:0] tbl_pipe_i,
   output hit_t                 hit_o,
   output logic                 any_o,
   output logic                 upload_o,
   output logic [1:0]           pipe_o
);
   localparam int READ_END = SLOT_READ0 + READ_CNT;

   if (READ_CNT < 1) begin : g_bad_rd
      $error("READ_CNT must be at least 1");
   end
   if (N_SLOTS < READ_END) begin : g_bad_slots
      $error("N_SLOTS too small for fixed layout");
   end

   logic [N_SLOTS-1:0] slot_hit;

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      assign slot_hit[i] = tbl_valid_i[i] && (tbl_opcode_i[8*i +: 8] == byte_i);
   end

   always_comb begin
      hit_o      = '0;
      hit_o.stat = |slot_hit[SLOT_STAT0 +: STAT_CNT];
      hit_o.id   = slot_hit[SLOT_ID];
      hit_o.disc = slot_hit[SLOT_DISC];
      hit_o.rd   = |slot_hit[SLOT_READ0 +: READ_CNT];
      hit_o.en4b = slot_hit[SLOT_EN4B];
      hit_o.ex4b = slot_hit[SLOT_EX4B];
      hit_o.wren = slot_hit[SLOT_WREN];
      hit_o.wrdi = slot_hit[SLOT_WRDI];
   end

   // attributes of the lowest-numbered matching slot
   always_comb begin
      upload_o = 1'b0;
      pipe_o   = 2'b00;
      for (int i = N_SLOTS-1; i >= 0; i--) begin
         if (slot_hit[i]) begin
            upload_o = tbl_upload_i[i];
            pipe_o   = tbl_pipe_i[2*i +: 2];
         end
      end
   end

   assign any_o = |slot_hit;
endmodule

// File: rtl/spi_opdisp_fsm.sv
module spi_opdisp_fsm
   import spi_opdisp_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active_i,
   input  logic            flash_i,
   input  logic            busy_i,
   input  logic            byte_valid_i,
   input  hit_t            hit_i,
   input  logic            any_i,
   input  logic            upload_i,
   input  logic [1:0]      pipe_i,
   input  logic [2:0]      icpt_en_i,
   output logic [DP_W-1:0] dp_sel_o,
   output logic            taken_o,
   output logic            addr_enter_o,
   output logic            wr_enable_o,
   output logic [2:0]      fwd_o,
   output logic            pipe2_o
);
   state_e     st_q, st_d;
   logic       addr_q, addr_d, wr_q, wr_d, pipe_q, pipe_d;
   logic [2:0] fwd_q, fwd_d;
   logic       accept;

   assign accept = (st_q == ST_IDLE) && active_i && byte_valid_i;

   always_comb begin
      st_d   = st_q;
      addr_d = addr_q;
      wr_d   = wr_q;
      fwd_d  = fwd_q;
      pipe_d = pipe_q;
      if (accept) begin
         pipe_d = (pipe_i == PIPE_HALF) || (pipe_i == PIPE_FULL);
         if (!any_i) begin
            st_d = ST_WAIT;
         end else if (hit_i.stat) begin
            if (flash_i || icpt_en_i[0]) st_d = ST_STAT;
            else begin st_d = ST_WAIT; fwd_d[0] = 1'b1; end
         end else if (hit_i.id) begin
            if (flash_i || icpt_en_i[1]) st_d = ST_ID;
            else begin st_d = ST_WAIT; fwd_d[1] = 1'b1; end
         end else if (hit_i.disc) begin
            if (flash_i || icpt_en_i[2]) st_d = ST_DISC;
            else begin st_d = ST_WAIT; fwd_d[2] = 1'b1; end
         end else if (hit_i.rd) begin
            st_d = ST_READ;
         end else if (upload_i && !busy_i) begin
            st_d = ST_UPLD;
         end else if ((hit_i.en4b || hit_i.ex4b) && !busy_i) begin
            st_d   = ST_ADDR;
            addr_d = hit_i.en4b;
         end else if ((hit_i.wren || hit_i.wrdi) && !busy_i) begin
            st_d = ST_WRL;
            wr_d = hit_i.wren;
         end else begin
            st_d = ST_WAIT;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= 1'b0;
         wr_q   <= 1'b0;
         fwd_q  <= 3'b000;
         pipe_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         addr_q <= addr_d;
         wr_q   <= wr_d;
         fwd_q  <= fwd_d;
         pipe_q <= pipe_d;
      end
   end

   always_comb begin
      dp_sel_o = '0;
      case (st_q)
         ST_STAT: dp_sel_o[DP_STAT] = 1'b1;
         ST_ID:   dp_sel_o[DP_ID]   = 1'b1;
         ST_DISC: dp_sel_o[DP_DISC] = 1'b1;
         ST_READ: dp_sel_o[DP_READ] = 1'b1;
         ST_UPLD: dp_sel_o[DP_UPLD] = 1'b1;
         ST_ADDR: dp_sel_o[DP_ADDR] = 1'b1;
         ST_WRL:  dp_sel_o[DP_WRL]  = 1'b1;
         default: dp_sel_o = '0;
      endcase
   end

   assign taken_o      = (st_q != ST_IDLE);
   assign addr_enter_o = addr_q;
   assign wr_enable_o  = wr_q;
   assign fwd_o        = fwd_q;
   assign pipe2_o      = pipe_q;

   // R10
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dp_sel_o));
   // R7
   hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(st_q));
   // R6
   inactive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_IDLE) && !active_i) |=> (st_q == ST_IDLE));
   // R4
   busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && busy_i) |=> (st_q != ST_ADDR) && (st_q != ST_WRL) && (st_q != ST_UPLD));
   // R1
   nomatch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !any_i) |=> (st_q == ST_WAIT));
   // R8
   fwd_only_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_q != 3'b000) |-> (st_q == ST_WAIT) && !flash_i);
endmodule

// File: rtl/spi_opdisp.sv
module spi_opdisp
   import spi_opdisp_pkg::*;
#(
   parameter int N_SLOTS  = 20,
   parameter int READ_CNT = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           mode_i,
   input  logic                 busy_i,
   input  logic                 byte_valid_i,
   input  logic [7:0]           byte_i,
   input  logic [N_SLOTS-1:0]   tbl_valid_i,
   input  logic [8*N_SLOTS-1:0] tbl_opcode_i,
   input  logic [N_SLOTS-1:0]   tbl_upload_i,
   input  logic [2*N_SLOTS-1:0] tbl_pipe_i,
   input  logic [2:0]           icpt_en_i,
   output logic [6:0]           dp_sel_o,
   output logic                 cmd_taken_o,
   output logic                 addr4b_enter_o,
   output logic                 wr_enable_o,
   output logic [2:0]           fwd_o,
   output logic                 pipe2_o
);
   hit_t       hit;
   logic       any_hit, upload, flash, active;
   logic [1:0] pipe;

   assign flash  = (mode_i == MODE_FLASH);
   assign active = flash || (mode_i == MODE_PASS);

   spi_opdisp_match #(.N_SLOTS(N_SLOTS), .READ_CNT(READ_CNT)) u_match (
      .byte_i       (byte_i),
      .tbl_valid_i  (tbl_valid_i),
      .tbl_opcode_i (tbl_opcode_i),
      .tbl_upload_i (tbl_upload_i),
      .tbl_pipe_i   (tbl_pipe_i),
      .hit_o        (hit),
      .any_o        (any_hit),
      .upload_o     (upload),
      .pipe_o       (pipe)
   );

   spi_opdisp_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .active_i     (active),
      .flash_i      (flash),
      .busy_i       (busy_i),
      .byte_valid_i (byte_valid_i),
      .hit_i        (hit),
      .any_i        (any_hit),
      .upload_i     (upload),
      .pipe_i       (pipe),
      .icpt_en_i    (icpt_en_i),
      .dp_sel_o     (dp_sel_o),
      .taken_o      (cmd_taken_o),
      .addr_enter_o (addr4b_enter_o),
      .wr_enable_o  (wr_enable_o),
      .fwd_o        (fwd_o),
      .pipe2_o      (pipe2_o)
   );
endmodule

// File: tb/sim_spi_opdisp.sv
`timescale 1ns/1ps
module sim_spi_opdisp;
   localparam int N = 20;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     mode_i = 2'b01;
   logic           busy_i = 1'b0;
   logic           byte_valid_i = 1'b0;
   logic [7:0]     byte_i = 8'h00;
   logic [N-1:0]   tbl_valid_i = '0;
   logic [8*N-1:0] tbl_opcode_i = '0;
   logic [N-1:0]   tbl_upload_i = '0;
   logic [2*N-1:0] tbl_pipe_i = '0;
   logic [2:0]     icpt_en_i = 3'b000;
   logic [6:0]     dp_sel_o;
   logic           cmd_taken_o, addr4b_enter_o, wr_enable_o, pipe2_o;
   logic [2:0]     fwd_o;

   always #2.5 clk = ~clk;

   spi_opdisp #(.N_SLOTS(N), .READ_CNT(6)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .busy_i(busy_i),
      .byte_valid_i(byte_valid_i), .byte_i(byte_i),
      .tbl_valid_i(tbl_valid_i), .tbl_opcode_i(tbl_opcode_i),
      .tbl_upload_i(tbl_upload_i), .tbl_pipe_i(tbl_pipe_i),
      .icpt_en_i(icpt_en_i), .dp_sel_o(dp_sel_o), .cmd_taken_o(cmd_taken_o),
      .addr4b_enter_o(addr4b_enter_o), .wr_enable_o(wr_enable_o),
      .fwd_o(fwd_o), .pipe2_o(pipe2_o)
   );

   typedef struct {
      logic [13:0] v;   // {sel, taken, addr, wr, fwd, pipe}
      string       tag;
   } exp_t;

   exp_t q[$];
   event smp_ev;
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   // monitor: pops one expected item per sample event
   initial begin
      forever begin
         @(smp_ev);
         if (q.size() != 0) begin
            exp_t e;
            logic [13:0] act;
            e   = q.pop_front();
            act = {dp_sel_o, cmd_taken_o, addr4b_enter_o, wr_enable_o, fwd_o, pipe2_o};
            checks++;
            if (act !== e.v) begin
               errors++;
               $display("FAIL %s actual=%b expected=%b", e.tag, act, e.v);
            end
         end
      end
   end

   task automatic put_slot(input int s, input logic [7:0] op, input logic upl,
                           input logic [1:0] pm);
      tbl_valid_i[s]          = 1'b1;
      tbl_opcode_i[8*s +: 8]  = op;
      tbl_upload_i[s]         = upl;
      tbl_pipe_i[2*s +: 2]    = pm;
   endtask

   task automatic txn(input logic [1:0] md, input logic bz, input logic [2:0] en,
                      input logic send, input logic [7:0] op1,
                      input logic two, input logic [7:0] op2,
                      input logic [6:0] esel, input logic etk, input logic ead,
                      input logic ewr, input logic [2:0] efw, input logic epp,
                      input string tag);
      exp_t e;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      mode_i = md; busy_i = bz; icpt_en_i = en;
      @(negedge clk);
      byte_valid_i = send; byte_i = op1;
      @(negedge clk);
      byte_valid_i = two; byte_i = op2;
      @(negedge clk);
      byte_valid_i = 1'b0;
      @(negedge clk);
      e.v   = {esel, etk, ead, ewr, efw, epp};
      e.tag = tag;
      q.push_back(e);
      -> smp_ev;
      #1;
   endtask

   initial begin
      put_slot(0, 8'h05, 1'b0, 2'b00);
      put_slot(1, 8'h35, 1'b0, 2'b00);
      put_slot(2, 8'h15, 1'b0, 2'b00);
      put_slot(3, 8'h9F, 1'b0, 2'b00);
      put_slot(4, 8'h5A, 1'b0, 2'b00);
      put_slot(5, 8'hB7, 1'b0, 2'b00);
      put_slot(6, 8'hE9, 1'b0, 2'b00);
      put_slot(7, 8'h06, 1'b0, 2'b00);
      put_slot(8, 8'h04, 1'b0, 2'b00);
      put_slot(9, 8'h03, 1'b1, 2'b00);   // read slot with upload attr (R11)
      put_slot(10, 8'h0B, 1'b0, 2'b01);
      put_slot(11, 8'h3B, 1'b0, 2'b10);
      put_slot(12, 8'h6B, 1'b0, 2'b11);
      put_slot(15, 8'h02, 1'b1, 2'b00);
      tbl_opcode_i[8*17 +: 8] = 8'h77;   // slot 17 disabled

      // R10 reset state, no byte sent
      txn(2'b01, 0, 3'b000, 0, 8'h00, 0, 8'h00, 7'h00, 0, 0, 0, 3'b000, 0, "R10 reset");
      // R2 three status slots
      txn(2'b01, 0, 3'b000, 1, 8'h05, 0, 8'h00, 7'h01, 1, 0, 0, 3'b000, 0, "R2 slot0");
      txn(2'b01, 0, 3'b000, 1, 8'h35, 0, 8'h00, 7'h01, 1, 0, 0, 3'b000, 0, "R2 slot1");
      txn(2'b01, 0, 3'b000, 1, 8'h15, 0, 8'h00, 7'h01, 1, 0, 0, 3'b000, 0, "R2 slot2");
      // R3 ID, discovery, read
      txn(2'b01, 0, 3'b000, 1, 8'h9F, 0, 8'h00, 7'h02, 1, 0, 0, 3'b000, 0, "R3 id");
      txn(2'b01, 0, 3'b000, 1, 8'h5A, 0, 8'h00, 7'h04, 1, 0, 0, 3'b000, 0, "R3 disc");
      // R9 pipeline flag
      txn(2'b01, 0, 3'b000, 1, 8'h0B, 0, 8'h00, 7'h08, 1, 0, 0, 3'b000, 1, "R9 half");
      txn(2'b01, 0, 3'b000, 1, 8'h3B, 0, 8'h00, 7'h08, 1, 0, 0, 3'b000, 1, "R9 full");
      txn(2'b01, 0, 3'b000, 1, 8'h6B, 0, 8'h00, 7'h08, 1, 0, 0, 3'b000, 0, "R9 rsvd");
      // R4 address width and write latch
      txn(2'b01, 0, 3'b000, 1, 8'hB7, 0, 8'h00, 7'h20, 1, 1, 0, 3'b000, 0, "R4 en4b");
      txn(2'b01, 0, 3'b000, 1, 8'hE9, 0, 8'h00, 7'h20, 1, 0, 0, 3'b000, 0, "R4 ex4b");
      txn(2'b01, 1, 3'b000, 1, 8'hB7, 0, 8'h00, 7'h00, 1, 0, 0, 3'b000, 0, "R4 en4b busy");
      txn(2'b01, 0, 3'b000, 1, 8'h06, 0, 8'h00, 7'h40, 1, 0, 1, 3'b000, 0, "R4 wren");
      txn(2'b01, 0, 3'b000, 1, 8'h04, 0, 8'h00, 7'h40, 1, 0, 0, 3'b000, 0, "R4 wrdi");
      txn(2'b10, 1, 3'b000, 1, 8'h04, 0, 8'h00, 7'h00, 1, 0, 0, 3'b000, 0, "R4 wrdi busy");
      // R5 upload
      txn(2'b01, 0, 3'b000, 1, 8'h02, 0, 8'h00, 7'h10, 1, 0, 0, 3'b000, 0, "R5 upload");
      txn(2'b01, 1, 3'b000, 1, 8'h02, 0, 8'h00, 7'h00, 1, 0, 0, 3'b000, 0, "R5 upload busy");
      // R1 disabled slot and unknown byte
      txn(2'b01, 0, 3'b000, 1, 8'h77, 0, 8'h00, 7'h00, 1, 0, 0, 3'b000, 0, "R1 disabled");
      txn(2'b01, 0, 3'b000, 1, 8'hAA, 0, 8'h00, 7'h00, 1, 0, 0, 3'b000, 0, "R1 nomatch");
      // R6 inactive modes, passthrough active
      txn(2'b00, 0, 3'b000, 1, 8'h05, 0, 8'h00, 7'h00, 0, 0, 0, 3'b000, 0, "R6 mode00");
      txn(2'b11, 0, 3'b000, 1, 8'h9F, 0, 8'h00, 7'h00, 0, 0, 0, 3'b000, 0, "R6 mode11");
      txn(2'b10, 0, 3'b000, 1, 8'h0B, 0, 8'h00, 7'h08, 1, 0, 0, 3'b000, 1, "R6 pass read");
      // R8 passthrough keep-local / forward
      txn(2'b10, 0, 3'b001, 1, 8'h05, 0, 8'h00, 7'h01, 1, 0, 0, 3'b000, 0, "R8 stat local");
      txn(2'b10, 0, 3'b110, 1, 8'h05, 0, 8'h00, 7'h00, 1, 0, 0, 3'b001, 0, "R8 stat fwd");
      txn(2'b10, 0, 3'b101, 1, 8'h9F, 0, 8'h00, 7'h00, 1, 0, 0, 3'b010, 0, "R8 id fwd");
      txn(2'b10, 0, 3'b011, 1, 8'h5A, 0, 8'h00, 7'h00, 1, 0, 0, 3'b100, 0, "R8 disc fwd");
      txn(2'b10, 0, 3'b100, 1, 8'h5A, 0, 8'h00, 7'h04, 1, 0, 0, 3'b000, 0, "R8 disc local");
      txn(2'b01, 0, 3'b000, 1, 8'h9F, 0, 8'h00, 7'h02, 1, 0, 0, 3'b000, 0, "R8 flash local");
      // R7 later bytes ignored
      txn(2'b01, 0, 3'b000, 1, 8'h9F, 1, 8'h05, 7'h02, 1, 0, 0, 3'b000, 0, "R7 second byte");
      txn(2'b01, 0, 3'b000, 1, 8'hAA, 1, 8'hB7, 7'h00, 1, 0, 0, 3'b000, 0, "R7 wait holds");
      // R11 read beats upload attribute
      txn(2'b01, 0, 3'b000, 1, 8'h03, 0, 8'h00, 7'h08, 1, 0, 0, 3'b000, 0, "R11 priority");

      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule